// File: doc/BRIEF.md
# Expanding Opcode Instruction Classifier

This block takes a fixed 16-bit instruction word and decides how many address fields it carries. The opcode length grows as escape prefixes are consumed. An 8-bit leading opcode marks a two-address instruction. When that byte holds one of the reserved values at the top of its range, a further 4 bits are added and the word becomes a one-address instruction. The last few of those 12-bit patterns are reserved again and take the final 4 bits as well, which gives a zero-address instruction with a 16-bit opcode.

A decode stage feeds the classifier one valid-qualified word per cycle. One cycle later the classifier returns a registered result:

- the format class;
- an opcode number that counts from zero inside its class;
- the address fields that the class uses, with any unused field driven to zero;
- a flag for encodings that fall outside the configured zero-address range.

The counts of two-address, one-address and zero-address instructions are parameters. Their defaults are 250, 92 and 64, which fill the whole 16-bit space.

Top module: `expop_classifier`

## Requirements
- R1: While reset is asserted and after it is released, before any valid input, `outValid`, `outClass`, `outOpcode`, `outAddrA`, `outAddrB` and `outIllegal` are all zero.
- R2: `outValid` is high exactly in the cycle after a cycle in which `inValid` was high, and low after a cycle with `inValid` low.
- R3: If bits [15:8] of a valid word are below 250, the result is class 2 (`outClass`=2'd2). The opcode equals bits [15:8], `outAddrA` equals bits [7:4] and `outAddrB` equals bits [3:0].
- R4: If bits [15:8] are 250 or more and bits [15:4] are below 4092, the result is class 1 (`outClass`=2'd1). The opcode equals bits [15:4] minus 4000, `outAddrA` equals bits [3:0] and `outAddrB` is zero.
- R5: If bits [15:4] are 4092 or more, the result is class 0 (`outClass`=2'd0). The opcode equals the whole word minus 65472, and both address outputs are zero.
- R6: `outIllegal` is raised only together with class 0, and only when the zero-address number reaches the configured zero-address count. With the default counts it stays low for all 65536 words.
- R7: The boundaries between classes decode as follows:
  - 0xF9FF gives class 2, opcode 249;
  - 0xFA00 gives class 1, opcode 0;
  - 0xFFBF gives class 1, opcode 91;
  - 0xFFC0 gives class 0, opcode 0;
  - 0xFFFF gives class 0, opcode 63.
- R8: After a cycle with `inValid` low, `outClass`, `outOpcode`, `outAddrA`, `outAddrB` and `outIllegal` keep their previous values, whatever word was presented.
- R9: `outClass` never takes the value 2'd3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Instruction word is present this cycle |
| instr | input | 16 | Instruction word |
| outValid | output | 1 | Registered result is valid |
| outClass | output | 2 | Number of address fields: 2, 1 or 0 |
| outOpcode | output | 8 | Opcode number, dense within its class |
| outAddrA | output | 4 | First address field, zero when unused |
| outAddrB | output | 4 | Second address field, zero when unused |
| outIllegal | output | 1 | Zero-address number lies beyond the configured count |

## Verification
All 65536 instruction words are presented back to back, in ascending order. This walks through every class and every escape prefix, and it separates an off-by-one in either escape threshold from an error in the dense opcode offsets.

The five words at the class edges are also checked against fixed expected values. Because those values are written out by hand rather than produced by the bench's own arithmetic, the sweep model is checked against them too.

A valid word followed by an idle cycle that carries a different word tells apart a design that updates its outputs only on valid data from one that tracks the input every cycle.

// File: rtl/expop_pkg.sv
package expop_pkg;

  typedef enum logic [1:0] {
    CLS_ZERO = 2'd0,
    CLS_ONE  = 2'd1,
    CLS_TWO  = 2'd2
  } fmtClass_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic selTwo;
    logic selOne;
    logic selZero;
    logic illegal;
  } ctrlStrobe_t;

  function automatic int opcWidth(input int twoCnt, input int oneCnt, input int zeroCnt);
    int m;
    m = twoCnt;
    if (oneCnt > m) m = oneCnt;
    if (zeroCnt > m) m = zeroCnt;
    return (m < 2) ? 1 : $clog2(m);
  endfunction

endpackage

// File: rtl/expop_ctrl.sv
module expop_ctrl
  import expop_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int FIELD_W  = 4,
  parameter int TWO_CNT  = 250,
  parameter int ONE_CNT  = 92,
  parameter int ZERO_CNT = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inValid,
  input  logic [WORD_W-1:0] instr,
  output ctrlStrobe_t       strobe,
  output logic              validQ
);

  localparam int TOP_W     = WORD_W - 2*FIELD_W;
  localparam int PRE_W     = WORD_W - FIELD_W;
  localparam int ONE_LIMIT = TWO_CNT * (2**FIELD_W) + ONE_CNT;
  localparam int ALL_LIMIT = ONE_LIMIT * (2**FIELD_W) + ZERO_CNT;
  localparam int FULL_ZERO = ((2**PRE_W) - ONE_LIMIT) * (2**FIELD_W);

  localparam logic [TOP_W:0]  TWO_LIM = (TOP_W+1)'(TWO_CNT);
  localparam logic [PRE_W:0]  ONE_LIM = (PRE_W+1)'(ONE_LIMIT);
  localparam logic [WORD_W:0] ALL_LIM = (WORD_W+1)'(ALL_LIMIT);

  logic [TOP_W-1:0] topBits;
  logic [PRE_W-1:0] prefix;
  logic             twoHit;
  logic             oneHit;
  logic             overRange;

  assign topBits = instr[WORD_W-1 -: TOP_W];
  assign prefix  = instr[WORD_W-1 -: PRE_W];
  assign twoHit  = ({1'b0, topBits} < TWO_LIM);
  assign oneHit  = ({1'b0, prefix} < ONE_LIM);

  // zero-address space either fully used or partially reserved
  generate
    if (ZERO_CNT >= FULL_ZERO) begin : g_fullZero
      assign overRange = 1'b0;
    end else begin : g_partZero
      assign overRange = !({1'b0, instr} < ALL_LIM);
    end
  endgenerate

  always_comb begin
    strobe.load    = inValid;
    strobe.selTwo  = twoHit;
    strobe.selOne  = !twoHit && oneHit;
    strobe.selZero = !twoHit && !oneHit;
    strobe.illegal = !twoHit && !oneHit && overRange;
  end

  always_ff @(posedge clk) begin
    if (rst) validQ <= 1'b0;
    else     validQ <= inValid;
  end

endmodule

// File: rtl/expop_datapath.sv
module expop_datapath
  import expop_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int FIELD_W  = 4,
  parameter int TWO_CNT  = 250,
  parameter int ONE_CNT  = 92,
  parameter int OPC_W    = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [WORD_W-1:0]  instr,
  input  ctrlStrobe_t        strobe,
  output fmtClass_e          classQ,
  output logic [OPC_W-1:0]   opcodeQ,
  output logic [FIELD_W-1:0] addrAQ,
  output logic [FIELD_W-1:0] addrBQ,
  output logic               illegalQ
);

  localparam int TOP_W = WORD_W - 2*FIELD_W;
  localparam int PRE_W = WORD_W - FIELD_W;
  localparam logic [PRE_W-1:0]  ONE_BASE  = PRE_W'(TWO_CNT * (2**FIELD_W));
  localparam logic [WORD_W-1:0] ZERO_BASE = WORD_W'((TWO_CNT * (2**FIELD_W) + ONE_CNT) * (2**FIELD_W));

  logic [TOP_W-1:0]   topBits;
  logic [PRE_W-1:0]   prefix;
  logic [FIELD_W-1:0] midField;
  logic [FIELD_W-1:0] lowField;

  fmtClass_e          classD;
  logic [OPC_W-1:0]   opcodeD;
  logic [FIELD_W-1:0] addrAD;
  logic [FIELD_W-1:0] addrBD;

  assign topBits  = instr[WORD_W-1 -: TOP_W];
  assign prefix   = instr[WORD_W-1 -: PRE_W];
  assign midField = instr[2*FIELD_W-1 -: FIELD_W];
  assign lowField = instr[FIELD_W-1:0];

  always_comb begin
    classD  = CLS_ZERO;
    opcodeD = OPC_W'(instr - ZERO_BASE);
    addrAD  = '0;
    addrBD  = '0;
    if (strobe.selTwo) begin
      classD  = CLS_TWO;
      opcodeD = OPC_W'(topBits);
      addrAD  = midField;
      addrBD  = lowField;
    end else if (strobe.selOne) begin
      classD  = CLS_ONE;
      opcodeD = OPC_W'(prefix - ONE_BASE);
      addrAD  = lowField;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      classQ   <= CLS_ZERO;
      opcodeQ  <= '0;
      addrAQ   <= '0;
      addrBQ   <= '0;
      illegalQ <= 1'b0;
    end else if (strobe.load) begin
      classQ   <= classD;
      opcodeQ  <= opcodeD;
      addrAQ   <= addrAD;
      addrBQ   <= addrBD;
      illegalQ <= strobe.illegal;
    end
  end

endmodule

// File: rtl/expop_classifier.sv
module expop_classifier
  import expop_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int FIELD_W  = 4,
  parameter int TWO_CNT  = 250,
  parameter int ONE_CNT  = 92,
  parameter int ZERO_CNT = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                inValid,
  input  logic [WORD_W-1:0]   instr,
  output logic                outValid,
  output logic [1:0]          outClass,
  output logic [opcWidth(TWO_CNT, ONE_CNT, ZERO_CNT)-1:0] outOpcode,
  output logic [FIELD_W-1:0]  outAddrA,
  output logic [FIELD_W-1:0]  outAddrB,
  output logic                outIllegal
);

  localparam int OPC_W = opcWidth(TWO_CNT, ONE_CNT, ZERO_CNT);

  ctrlStrobe_t strobe;
  fmtClass_e   classQ;

  expop_ctrl #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W),
    .TWO_CNT(TWO_CNT), .ONE_CNT(ONE_CNT), .ZERO_CNT(ZERO_CNT)
  ) i_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .strobe(strobe), .validQ(outValid)
  );

  expop_datapath #(
    .WORD_W(WORD_W), .FIELD_W(FIELD_W),
    .TWO_CNT(TWO_CNT), .ONE_CNT(ONE_CNT), .OPC_W(OPC_W)
  ) i_dp (
    .clk(clk), .rst(rst), .instr(instr), .strobe(strobe),
    .classQ(classQ), .opcodeQ(outOpcode), .addrAQ(outAddrA),
    .addrBQ(outAddrB), .illegalQ(outIllegal)
  );

  assign outClass = classQ;

endmodule

// File: rtl/expop_checker.sv
module expop_checker #(
  parameter int WORD_W  = 16,
  parameter int FIELD_W = 4,
  parameter int TWO_CNT = 250,
  parameter int OPC_W   = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [WORD_W-1:0]  instr,
  input logic               outValid,
  input logic [1:0]         outClass,
  input logic [OPC_W-1:0]   outOpcode,
  input logic [FIELD_W-1:0] outAddrA,
  input logic [FIELD_W-1:0] outAddrB,
  input logic               outIllegal
);

  localparam int TOP_W = WORD_W - 2*FIELD_W;
  localparam logic [TOP_W:0] TWO_LIM = (TOP_W+1)'(TWO_CNT);

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  a_r2_idle_clears: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  a_r3_two_fields: assert property (@(posedge clk) disable iff (rst)
    (inValid && ({1'b0, instr[WORD_W-1 -: TOP_W]} < TWO_LIM)) |=>
      (outClass == 2'd2 && outAddrA == $past(instr[2*FIELD_W-1 -: FIELD_W])
       && outAddrB == $past(instr[FIELD_W-1:0])));

  a_r4_one_no_second: assert property (@(posedge clk) disable iff (rst)
    (outValid && outClass == 2'd1) |-> (outAddrB == '0));

  a_r5_zero_no_fields: assert property (@(posedge clk) disable iff (rst)
    (outValid && outClass == 2'd0) |-> (outAddrA == '0 && outAddrB == '0));

  a_r6_illegal_zero_only: assert property (@(posedge clk) disable iff (rst)
    outIllegal |-> (outClass == 2'd0));

  a_r8_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> ($stable(outClass) && $stable(outOpcode) && $stable(outAddrA)
                  && $stable(outAddrB) && $stable(outIllegal)));

  a_r9_no_class3: assert property (@(posedge clk) disable iff (rst)
    outClass != 2'd3);

endmodule

bind expop_classifier expop_checker #(
  .WORD_W(WORD_W), .FIELD_W(FIELD_W), .TWO_CNT(TWO_CNT), .OPC_W(OPC_W)
) i_checker (
  .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
  .outValid(outValid), .outClass(outClass), .outOpcode(outOpcode),
  .outAddrA(outAddrA), .outAddrB(outAddrB), .outIllegal(outIllegal)
);

// File: tb/test_expop_classifier.sv
module test_expop_classifier;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [15:0] instr = '0;
  logic        outValid;
  logic [1:0]  outClass;
  logic [7:0]  outOpcode;
  logic [3:0]  outAddrA;
  logic [3:0]  outAddrB;
  logic        outIllegal;

  int total = 0;
  int failed = 0;
  bit done = 0;

  always #5 clk = ~clk;

  expop_classifier i_expop_classifier (
    .clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
    .outValid(outValid), .outClass(outClass), .outOpcode(outOpcode),
    .outAddrA(outAddrA), .outAddrB(outAddrB), .outIllegal(outIllegal)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // packed view: valid, class, opcode, addrA, addrB
  function automatic logic [18:0] outVec();
    return {outValid, outClass, outOpcode, outAddrA, outAddrB};
  endfunction

  function automatic logic [18:0] model(input logic [15:0] w);
    logic [15:0] d;
    if (w[15:8] < 8'd250) begin
      return {1'b1, 2'd2, w[15:8], w[7:4], w[3:0]};
    end else if (w[15:4] < 12'd4092) begin
      d = {4'd0, w[15:4]} - 16'd4000;
      return {1'b1, 2'd1, d[7:0], w[3:0], 4'd0};
    end else begin
      d = w - 16'd65472;
      return {1'b1, 2'd0, d[7:0], 4'd0, 4'd0};
    end
  endfunction

  function automatic string tagOf(input logic [15:0] w);
    if (w[15:8] < 8'd250) return "R3";
    if (w[15:4] < 12'd4092) return "R4";
    return "R5";
  endfunction

  task automatic edgeCase(input logic [15:0] w, input logic [1:0] cls, input logic [7:0] opc);
    @(negedge clk);
    inValid = 1'b1;
    instr = w;
    @(negedge clk);
    inValid = 1'b0;
    check("R7 class", 32'(outClass), 32'(cls));
    check("R7 opcode", 32'(outOpcode), 32'(opc));
  endtask

  initial begin
    #1_500_000;
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 during reset", 32'({outVec(), outIllegal}), 32'd0);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", 32'({outVec(), outIllegal}), 32'd0);

    // R7 boundaries, expected values written out
    edgeCase(16'hF9FF, 2'd2, 8'd249);
    edgeCase(16'hFA00, 2'd1, 8'd0);
    edgeCase(16'hFFBF, 2'd1, 8'd91);
    edgeCase(16'hFFC0, 2'd0, 8'd0);
    edgeCase(16'hFFFF, 2'd0, 8'd63);

    // R2 / R8: idle cycle with a different word must not disturb results
    @(negedge clk);
    inValid = 1'b1;
    instr = 16'h1234;
    @(negedge clk);
    check("R2 valid after input", 32'(outValid), 32'd1);
    check("R3 opcode 0x12", 32'(outOpcode), 32'h12);
    inValid = 1'b0;
    instr = 16'hFFC5;
    @(negedge clk);
    check("R2 idle clears valid", 32'(outValid), 32'd0);
    check("R8 hold fields", 32'({outClass, outOpcode, outAddrA, outAddrB, outIllegal}),
          32'({2'd2, 8'h12, 4'h3, 4'h4, 1'b0}));
    @(negedge clk);
    check("R8 hold second idle", 32'({outClass, outOpcode}), 32'({2'd2, 8'h12}));

    // exhaustive sweep, back to back
    for (int w = 0; w <= 65536; w++) begin
      @(negedge clk);
      if (w > 0) begin
        check(tagOf(16'(w - 1)), 32'(outVec()), 32'(model(16'(w - 1))));
        check("R6 illegal low", 32'(outIllegal), 32'd0);
        check("R9 class range", 32'(outClass == 2'd3), 32'd0);
      end
      if (w < 65536) begin
        inValid = 1'b1;
        instr = 16'(w);
      end else begin
        inValid = 1'b0;
      end
    end
    @(negedge clk);
    check("R2 idle after sweep", 32'(outValid), 32'd0);

    done = 1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule